// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block generates the internal reset of a small microcontroller core. An active-low reset pin is one source. The other is an optional power-on source, which is enabled by a configuration input. The supply is represented by a synchronous power-good input. When the power-on source is enabled and power-good is low, reset is asserted at once, without waiting for a clock, and a 12-bit idle down-counter is preset to all ones. When power-good rises, the counter runs down, and reset is released only when the counter underflows. That happens 4096 clock edges after the rise.

The pin path works differently. The pin passes through a two-flop synchronizer and then a width qualifier. A low pulse shorter than one instruction cycle (a parameter, 10 clocks by default) never reaches the core. While reset is active, a small bank of architectural state is held at its reset values. The bank holds the program counter, the port directions, the output-only port data, the control registers, the stack pointer and the watchdog configuration. Any writes that arrive while reset is active are dropped.

When reset is released, the core owns the bank. The watchdog and clock monitor stay inhibited for the whole reset. A one-clock start pulse tells them when to begin operating. The write port has no back-pressure: it is a single-cycle strobe that is accepted on any clock edge where reset is inactive, and there is no ready signal. Reads are combinational.

Top module: `rstseq_top`

## Requirements
- R1: When `por_en`=1 and `pwr_good`=0, `core_rst_n` is low with no clock edge needed, and it stays low for as long as that condition lasts.
- R2: When `por_en`=0, `pwr_good` has no effect. Reset does not assert, and the bank contents are kept.
- R3: After `pwr_good` rises with `por_en`=1, `core_rst_n` goes high on exactly the 4096th rising clock edge (2^IDLE_W).
- R4: Once reset has been released, no further reset occurs while `pwr_good` stays high and the pin stays high.
- R5: The pin is sampled on rising edges. If it is low on INSTR_CYC consecutive edges 1..N, `core_rst_n` falls on edge N+2. If the pin is seen high on edge L+1, `core_rst_n` rises on edge L+3. A pin that is low on fewer than INSTR_CYC edges causes no reset and leaves the bank unchanged.
- R6: During reset, the port direction registers at addresses 1 to 4 read 0x0000 (tri-state), and the output-only port data at address 5 reads 0x00FF.
- R7: During reset, the program counter at address 0 reads 0x0000. The status, control, interrupt-control, timer control, wake enable and wake edge registers at addresses 6 to 11 read 0x0000.
- R8: During reset, the stack pointer at address 12 reads 0x002F when RAM_BYTES=64 and 0x006F when RAM_BYTES=128.
- R9: During reset, the watchdog configuration at address 13 reads 0x0007. Bits [1:0] are the service window, at its maximum value 11. Bit 2 is the clock-monitor enable. `wd_inhibit` is high exactly while reset is active.
- R10: `wd_start` is high for exactly one clock cycle, starting at the edge that releases reset.
- R11: A write with `wr_en`=1 while reset is active is ignored. Once reset is inactive, a write stores `wr_data` masked to the register width: 16 bits at address 0, 3 bits at address 13, 8 bits elsewhere. Addresses 14 and 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| por_en | input | 1 | Enables the power-on reset source |
| pwr_good | input | 1 | Synchronous supply-good indication |
| wr_en | input | 1 | Bank write strobe |
| wr_addr | input | 4 | Bank write address |
| wr_data | input | 16 | Bank write data |
| rd_addr | input | 4 | Bank read address |
| core_rst_n | output | 1 | Internal reset to the core, active low |
| wd_inhibit | output | 1 | Holds off the watchdog and clock monitor |
| wd_start | output | 1 | One-clock pulse when reset is released |
| rd_data | output | 16 | Bank read data |

## Verification
The bench sweeps the pin's low time from one edge to three past the qualification limit, with the power-on source both enabled and disabled. It checks the exact edge on which reset asserts and releases, and the length of the start pulse. A qualifier that is off by one would either let a 9-edge pulse through or demand 11 edges. A synchronizer with the wrong depth would shift every edge. The bench counts the power-on hold to exactly 4096 edges, which exposes a counter that stops at zero instead of underflowing. The bench reads every bank address both during reset and after writes following release. This catches defaults that are wrong or that ignore RAM size, writes that are accepted during reset, and width masks that are missing.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;
  localparam int NREGS  = 14;

  localparam int A_PC    = 0;
  localparam int A_DIR0  = 1;
  localparam int A_OUTP  = 5;
  localparam int A_SP    = 12;
  localparam int A_WDCFG = 13;

  function automatic logic [REG_W-1:0] reg_default(input int idx, input int ram_bytes);
    case (idx)
      A_OUTP:  return REG_W'(16'h00FF);
      A_SP:    return (ram_bytes >= 128) ? REG_W'(16'h006F) : REG_W'(16'h002F);
      A_WDCFG: return REG_W'(16'h0007);
      default: return '0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] reg_mask(input int idx);
    case (idx)
      A_PC:    return '1;
      A_WDCFG: return REG_W'(16'h0007);
      default: return REG_W'(16'h00FF);
    endcase
  endfunction
endpackage

// File: rtl/rstseq_pinqual.sv
`timescale 1ns/1ps
module rstseq_pinqual #(
  parameter int INSTR_CYC = 10
) (
  input  logic clk,
  input  logic clr_n,
  input  logic pin_n,
  output logic pin_rst
);
  localparam int QW = $clog2(INSTR_CYC + 1);

  logic          s1, s2;
  logic [QW-1:0] q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q       <= '0;
      pin_rst <= 1'b0;
    end else if (!s2) begin
      if (q == QW'(INSTR_CYC - 1)) pin_rst <= 1'b1;
      else                         q       <= q + 1'b1;
    end else begin
      q       <= '0;
      pin_rst <= 1'b0;
    end
  end
endmodule

// File: rtl/rstseq_idle.sv
`timescale 1ns/1ps
module rstseq_idle #(
  parameter int IDLE_W = 12
) (
  input  logic clk,
  input  logic clr_n,
  output logic hold
);
  logic [IDLE_W-1:0] cnt;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      cnt  <= '1;
      hold <= 1'b1;
    end else if (hold) begin
      if (cnt == '0) hold <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rstseq_bank.sv
`timescale 1ns/1ps
module rstseq_bank
  import rstseq_pkg::*;
#(
  parameter int RAM_BYTES = 64
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              rst_act,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data
);
  logic [NREGS-1:0][REG_W-1:0] bank_q;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [REG_W-1:0] r;
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)                                  r <= reg_default(g, RAM_BYTES);
      else if (rst_act)                            r <= reg_default(g, RAM_BYTES);
      else if (wr_en && wr_addr == ADDR_W'(g))     r <= wr_data & reg_mask(g);
    end
    assign bank_q[g] = r;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = bank_q[i];
  end
endmodule

// File: rtl/rstseq_top.sv
`timescale 1ns/1ps
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int INSTR_CYC = 10,
  parameter int IDLE_W    = 12,
  parameter int RAM_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              por_en,
  input  logic              pwr_good,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              core_rst_n,
  output logic              wd_inhibit,
  output logic              wd_start,
  output logic [REG_W-1:0]  rd_data
);
  logic por_clr_n, por_hold, pin_rst, rst_act, rst_prev;

  // power-on clear: asynchronous, only when the power-on source is enabled
  assign por_clr_n = !(por_en && !pwr_good);

  rstseq_pinqual #(.INSTR_CYC(INSTR_CYC)) u_pin (
    .clk(clk), .clr_n(por_clr_n), .pin_n(rst_pin_n), .pin_rst(pin_rst));

  rstseq_idle #(.IDLE_W(IDLE_W)) u_idle (
    .clk(clk), .clr_n(por_clr_n), .hold(por_hold));

  assign rst_act = por_hold | pin_rst;

  always_ff @(posedge clk or negedge por_clr_n) begin
    if (!por_clr_n) rst_prev <= 1'b1;
    else            rst_prev <= rst_act;
  end

  rstseq_bank #(.RAM_BYTES(RAM_BYTES)) u_bank (
    .clk(clk), .clr_n(por_clr_n), .rst_act(rst_act),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data));

  assign core_rst_n = ~rst_act;
  assign wd_inhibit = rst_act;
  assign wd_start   = rst_prev & ~rst_act;
endmodule

// File: rtl/rstseq_chk.sv
`timescale 1ns/1ps
module rstseq_chk
  import rstseq_pkg::*;
#(
  parameter int RAM_BYTES = 64
) (
  input logic              clk,
  input logic              rst_pin_n,
  input logic              por_en,
  input logic              pwr_good,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [REG_W-1:0]  rd_data,
  input logic              core_rst_n,
  input logic              wd_inhibit,
  input logic              wd_start
);
  localparam logic [REG_W-1:0] SP_EXP = (RAM_BYTES >= 128) ? REG_W'(16'h006F) : REG_W'(16'h002F);
  logic clr;
  assign clr = por_en && !pwr_good;

  p_por_holds_r1: assert property (@(posedge clk) clr |-> (!core_rst_n && wd_inhibit));

  p_start_one_cycle_r10: assert property (@(posedge clk) disable iff (clr)
    wd_start |=> !wd_start);

  p_start_on_release_r10: assert property (@(posedge clk) disable iff (clr)
    $rose(core_rst_n) |-> wd_start);

  p_pin_qualified_r5: assert property (@(posedge clk) disable iff (clr)
    $fell(core_rst_n) |-> $past(!rst_pin_n, 3));

  p_sp_default_r8: assert property (@(posedge clk) disable iff (clr)
    !core_rst_n |=> (rd_addr != ADDR_W'(A_SP) || rd_data == SP_EXP));
endmodule

bind rstseq_top rstseq_chk #(.RAM_BYTES(RAM_BYTES)) u_chk (
  .clk(clk), .rst_pin_n(rst_pin_n), .por_en(por_en), .pwr_good(pwr_good),
  .rd_addr(rd_addr), .rd_data(rd_data), .core_rst_n(core_rst_n),
  .wd_inhibit(wd_inhibit), .wd_start(wd_start));

// File: tb/rstseq_top_test.sv
`timescale 1ns/1ps
module rstseq_top_test;
  localparam int N = 10;

  logic        clk = 1'b0;
  logic        rst_pin_n, por_en, pwr_good, wr_en;
  logic [3:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data, rd_big;
  logic        core_rst_n, wd_inhibit, wd_start;
  logic        rst_big, inh_big, start_big;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  rstseq_top #(.INSTR_CYC(N), .IDLE_W(12), .RAM_BYTES(64)) uut (
    .clk(clk), .rst_pin_n(rst_pin_n), .por_en(por_en), .pwr_good(pwr_good),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .core_rst_n(core_rst_n), .wd_inhibit(wd_inhibit), .wd_start(wd_start),
    .rd_data(rd_data));

  rstseq_top #(.INSTR_CYC(N), .IDLE_W(12), .RAM_BYTES(128)) uut_big (
    .clk(clk), .rst_pin_n(rst_pin_n), .por_en(por_en), .pwr_good(pwr_good),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .core_rst_n(rst_big), .wd_inhibit(inh_big), .wd_start(start_big),
    .rd_data(rd_big));

  function automatic logic [15:0] dflt(input int a);
    if (a == 5)  return 16'h00FF;
    if (a == 12) return 16'h002F;
    if (a == 13) return 16'h0007;
    return 16'h0000;
  endfunction

  function automatic logic [15:0] wmask(input int a);
    if (a == 0)  return 16'hFFFF;
    if (a == 13) return 16'h0007;
    if (a >= 14) return 16'h0000;
    return 16'h00FF;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    rd_addr = 4'(a); #1; d = rd_data;
  endtask

  task automatic pin_sweep(input int L);
    int first = 0, cnt = 0, pulse_at = 0;
    logic [15:0] v;
    wr(1, 16'h00C3);
    wr(7, 16'h003C);
    rst_pin_n = 1'b0;
    for (int e = 1; e <= L + 6; e++) begin
      tick();
      if (wr_en) wr_en = 1'b0;
      if (!core_rst_n) begin cnt++; if (first == 0) first = e; end
      if (wd_start) pulse_at = e;
      if (L >= N && e == L + 2)
        chk(wd_inhibit == 1'b1, "R9 inhibit during pin reset", 32'(wd_inhibit), 1);
      if (L > N && e == N + 2) begin
        wr_en = 1'b1; wr_addr = 4'd7; wr_data = 16'h0099;
      end
      if (e == L) rst_pin_n = 1'b1;
    end
    if (L >= N) begin
      chk(first == N + 2, "R5 pin assert edge", 32'(first), 32'(N + 2));
      chk(cnt == L - N + 1, "R5 pin reset length", 32'(cnt), 32'(L - N + 1));
      chk(pulse_at == L + 3, "R10 start pulse edge", 32'(pulse_at), 32'(L + 3));
      rd(1, v);  chk(v == 16'h0000, "R6 dir cleared by pin reset", 32'(v), 0);
      rd(12, v); chk(v == 16'h002F, "R8 sp after pin reset", 32'(v), 32'h2F);
      rd(7, v);
      if (L > N) chk(v == 16'h0000, "R11 write during reset ignored", 32'(v), 0);
    end else begin
      chk(cnt == 0, "R5 short pulse ignored", 32'(cnt), 0);
      chk(pulse_at == 0, "R10 no start pulse on short pulse", 32'(pulse_at), 0);
      rd(1, v); chk(v == 16'h00C3, "R5 bank kept on short pulse", 32'(v), 32'hC3);
    end
    repeat (3) tick();
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    por_en = 1'b1; pwr_good = 1'b0; rst_pin_n = 1'b1;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    #3;
    chk(core_rst_n == 1'b0, "R1 reset before any clock", 32'(core_rst_n), 0);
    chk(wd_inhibit == 1'b1, "R9 inhibit in reset", 32'(wd_inhibit), 1);
    repeat (3) tick();
    for (int a = 0; a < 14; a++) begin
      rd(a, v);
      chk(v == dflt(a), $sformatf("R6/R7/R8/R9 default addr %0d", a), 32'(v), 32'(dflt(a)));
    end
    rd(12, v); v = rd_big;
    chk(v == 16'h006F, "R8 sp with 128 bytes", 32'(v), 32'h6F);
    wr(0, 16'h1234);
    rd(0, v); chk(v == 16'h0000, "R11 write ignored during por", 32'(v), 0);
    chk(core_rst_n == 1'b0, "R1 reset held while power low", 32'(core_rst_n), 0);

    pwr_good = 1'b1;
    n = 0;
    for (int k = 0; k < 5000; k++) begin
      tick(); n++;
      if (core_rst_n) break;
    end
    chk(n == 4096, "R3 idle hold length", 32'(n), 4096);
    chk(wd_start == 1'b1, "R10 start pulse at release", 32'(wd_start), 1);
    tick();
    chk(wd_start == 1'b0, "R10 start pulse one cycle", 32'(wd_start), 0);

    for (int a = 0; a < 16; a++) wr(a, 16'hA5C3 ^ 16'(a * 16'h1111));
    for (int a = 0; a < 16; a++) begin
      rd(a, v);
      chk(v == ((16'hA5C3 ^ 16'(a * 16'h1111)) & wmask(a)),
          $sformatf("R11 write readback addr %0d", a), 32'(v),
          32'((16'hA5C3 ^ 16'(a * 16'h1111)) & wmask(a)));
    end

    n = 0;
    for (int k = 0; k < 5000; k++) begin
      tick();
      if (!core_rst_n || wd_start) n++;
    end
    chk(n == 0, "R4 no reset while power good", 32'(n), 0);

    for (int L = 1; L <= N + 3; L++) pin_sweep(L);

    por_en = 1'b0;
    tick();
    wr(3, 16'h005A);
    pwr_good = 1'b0;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      tick();
      if (!core_rst_n) n++;
    end
    chk(n == 0, "R2 power low ignored when disabled", 32'(n), 0);
    rd(3, v); chk(v == 16'h005A, "R2 bank kept when disabled", 32'(v), 32'h5A);
    pwr_good = 1'b1;
    tick();
    for (int L = 1; L <= N + 3; L++) pin_sweep(L);

    por_en = 1'b1;
    tick();
    pwr_good = 1'b0;
    #1;
    chk(core_rst_n == 1'b0, "R1 immediate assert on power loss", 32'(core_rst_n), 0);
    rd(5, v); chk(v == 16'h00FF, "R6 out port high on power loss", 32'(v), 32'hFF);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule